// File: doc/BRIEF.md
# DMA Bus Tenure Controller

This block is a single-channel DMA engine. It shares an external memory bus with a processor. Software programs a source word address, a destination word address, a word count and a holding policy, then pulses a start strobe. The engine asks an external arbiter for the bus with a request/grant pair. Once it owns the bus, it moves words one at a time. Each move reads the source word, writes it to the destination, advances both addresses by one word and lowers the remaining count.

The holding policy sets how long the engine keeps the bus, and so how long the processor can be kept waiting:
- **Single:** the bus is given back after every word.
- **Block:** the bus is kept until the whole block has moved.
- **Demand:** a peripheral request line paces the traffic. The engine keeps the bus while the peripheral asks for data, may sit idle on cycles while it owns the bus, and gives the bus back when the peripheral stops asking. The count is kept across these gaps.

A sticky done flag reports completion. After done is set, a new start strobe is needed before any further bus traffic.

Top module: `dma_tenure_ctrl`

## Requirements
- R1: A start strobe with a non-zero count clears done in the next cycle. The engine then raises bus_req once it has seen bus_gnt low.
- R2: The memory port (mem_valid) is active only while bus_gnt is high. No beat happens while the arbiter withholds the grant.
- R3: Each word move is a read beat (mem_we=0) at the source address, followed by a write beat (mem_we=1) at the destination address. The write data is the word returned by the read.
- R4: After each completed write beat, both addresses increase by one and the remaining count decreases by one.
- R5: A beat completes only on a cycle with mem_ready high. While mem_ready is low, mem_valid, mem_we and mem_addr hold steady.
- R6: Single mode (cfg_mode=0) performs exactly one word move per bus tenure, then drops bus_req. A new tenure starts only after bus_gnt has been seen low.
- R7: Block mode (cfg_mode=1) keeps bus_req high from the first word to the last, with one tenure per block. The next read beat follows each write beat with no idle owned cycle.
- R8: In demand mode (cfg_mode=2), a read beat starts only after periph_req was high on the deciding edge. The engine spends one owned idle cycle between word moves.
- R9: In demand mode, the engine drops bus_req at the end of the word in flight after periph_req goes low. It keeps the remaining count and resumes when periph_req returns.
- R10: When the last word is written, done goes high and stays high. The engine then makes no further bus request until a new start strobe.
- R11: A start strobe with a count of zero sets done in the next cycle and never raises bus_req.
- R12: Mode code 3 behaves as block mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_start | input | 1 | One-cycle start strobe, accepted only when idle |
| cfg_mode | input | 2 | Holding policy: 0 single, 1 block, 2 demand, 3 block |
| cfg_src_addr | input | AW (16) | First source word address |
| cfg_dst_addr | input | AW (16) | First destination word address |
| cfg_words | input | CW (16) | Number of words to move |
| periph_req | input | 1 | Peripheral transfer request (demand mode pacing) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_valid | output | 1 | Memory beat active |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW (16) | Word address of the beat |
| mem_wdata | output | DW (32) | Write data |
| mem_rdata | input | DW (32) | Read data, taken when mem_ready is high on a read beat |
| mem_ready | input | 1 | Beat completes on this cycle |
| done | output | 1 | Sticky completion flag |

## Verification
Some rules hold on every cycle, and the embedded properties check them:
- the port is used only under grant;
- beats stay stable through wait states;
- each completed write steps the counters;
- single mode releases the bus after every word and re-requests only after seeing the grant low;
- block mode continues straight into the next read;
- demand mode starts reads only on a peripheral request and releases on a gap;
- zero-count starts and a finished engine stay quiet.

Other behaviours need whole scenarios, and only the bench can show them. These are the number of tenures each policy produces for a block, the correct data and addresses of every word against an independent memory model, and the count surviving demand-mode gaps. The bench also covers grant withheld by a busy processor, and done staying set until the next start.

// File: rtl/dma_tenure_pkg.sv
package dma_tenure_pkg;

  typedef enum logic [1:0] {
    HOLD_SINGLE = 2'd0,
    HOLD_BLOCK  = 2'd1,
    HOLD_DEMAND = 2'd2,
    HOLD_BLOCK3 = 2'd3
  } hold_mode_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_PARK = 3'd1,
    TS_REQ  = 3'd2,
    TS_RD   = 3'd3,
    TS_WR   = 3'd4,
    TS_OWN  = 3'd5
  } tenure_st_e;

  typedef struct packed {
    logic load;
    logic cap;
    logic step;
  } regs_ctl_t;

  function automatic logic hold_is_block(hold_mode_e m);
    return (m == HOLD_BLOCK) || (m == HOLD_BLOCK3);
  endfunction

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_tenure_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  regs_ctl_t     ctl,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [DW-1:0] hold_word_q,
  output logic          cnt_last
);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] src_d, dst_d;
  logic          ptr_en;

  assign ptr_en = ctl.load | ctl.step;

  always_comb begin
    if (ctl.load) begin
      src_d = ld_src;
      dst_d = ld_dst;
      cnt_d = ld_cnt;
    end else begin
      src_d = src_q + ADDR_ONE;
      dst_d = dst_q + ADDR_ONE;
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_word_q <= '0;
    else if (ctl.cap) hold_word_q <= rd_word;
  end

  assign cnt_last = (cnt_q == CNT_ONE);

  // R4: a completed write advances both pointers and lowers the count
  p_step_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && !ctl.load) |=> (src_q == $past(src_q) + ADDR_ONE) &&
                                (dst_q == $past(dst_q) + ADDR_ONE) &&
                                (cnt_q == $past(cnt_q) - CNT_ONE));
endmodule

// File: rtl/dma_tenure_fsm.sv
module dma_tenure_fsm
  import dma_tenure_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] mode_in,
  input  logic       count_zero,
  input  logic       periph_req,
  input  logic       bus_gnt,
  input  logic       mem_ready,
  input  logic       cnt_last,
  output logic       bus_req,
  output logic       port_rd,
  output logic       port_wr,
  output logic       done,
  output regs_ctl_t  ctl
);
  tenure_st_e st_q, st_d;
  hold_mode_e mode_q, mode_d;
  logic       done_q, done_d;
  logic       is_dem, is_blk;

  assign is_dem = (mode_q == HOLD_DEMAND);
  assign is_blk = hold_is_block(mode_q);

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    done_d = done_q;
    ctl    = '0;
    unique case (st_q)
      TS_IDLE: if (start) begin
        mode_d = hold_mode_e'(mode_in);
        if (count_zero) begin
          done_d = 1'b1;
        end else begin
          done_d   = 1'b0;
          ctl.load = 1'b1;
          st_d     = TS_PARK;
        end
      end
      TS_PARK: if (!bus_gnt && (!is_dem || periph_req)) st_d = TS_REQ;
      TS_REQ: begin
        if (is_dem && !periph_req) st_d = TS_PARK;
        else if (bus_gnt)          st_d = TS_RD;
      end
      TS_RD: if (mem_ready) begin
        ctl.cap = 1'b1;
        st_d    = TS_WR;
      end
      TS_WR: if (mem_ready) begin
        ctl.step = 1'b1;
        if (cnt_last) begin
          done_d = 1'b1;
          st_d   = TS_IDLE;
        end else if (is_blk) begin
          st_d = TS_RD;
        end else if (is_dem) begin
          st_d = TS_OWN;
        end else begin
          st_d = TS_PARK;
        end
      end
      TS_OWN:  st_d = periph_req ? TS_RD : TS_PARK;
      default: st_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TS_IDLE;
      mode_q <= HOLD_SINGLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (st_q == TS_IDLE) mode_q <= mode_d;
    end
  end

  assign bus_req = (st_q == TS_REQ) || (st_q == TS_RD) ||
                   (st_q == TS_WR)  || (st_q == TS_OWN);
  assign port_rd = (st_q == TS_RD);
  assign port_wr = (st_q == TS_WR);
  assign done    = done_q;

  // R6: a new tenure begins only after the grant was seen low
  p_rereq_gnt_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !$past(bus_gnt));

  // R6: single mode gives the bus back after each word
  p_single_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && mem_ready && mode_q == HOLD_SINGLE) |=> !bus_req);

  // R7: block mode goes straight into the next read
  p_block_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && mem_ready && is_blk && !cnt_last) |=> (bus_req && port_rd));

  // R8: demand reads begin only on a peripheral request
  p_demand_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dem && port_rd && !$past(port_rd)) |-> $past(periph_req));

  // R9: an owned idle cycle with no request releases the bus
  p_demand_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_OWN && !periph_req) |=> !bus_req);

  // R10: a finished engine stays off the bus
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_req && !port_rd && !port_wr));

  // R11: zero-count start completes without a request
  p_zero_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_IDLE && start && count_zero) |=> (done && !bus_req));
endmodule

// File: rtl/dma_tenure_ctrl.sv
module dma_tenure_ctrl
  import dma_tenure_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic [1:0]    cfg_mode,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [CW-1:0] cfg_words,
  input  logic          periph_req,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          done
);
  logic          rst_i_n;
  regs_ctl_t     ctl;
  logic          cnt_last, port_rd, port_wr;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] word_q;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  dma_tenure_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start      (cfg_start),
    .mode_in    (cfg_mode),
    .count_zero (cfg_words == '0),
    .periph_req (periph_req),
    .bus_gnt    (bus_gnt),
    .mem_ready  (mem_ready),
    .cnt_last   (cnt_last),
    .bus_req    (bus_req),
    .port_rd    (port_rd),
    .port_wr    (port_wr),
    .done       (done),
    .ctl        (ctl)
  );

  dma_xfer_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .ctl         (ctl),
    .ld_src      (cfg_src_addr),
    .ld_dst      (cfg_dst_addr),
    .ld_cnt      (cfg_words),
    .rd_word     (mem_rdata),
    .src_q       (src_q),
    .dst_q       (dst_q),
    .hold_word_q (word_q),
    .cnt_last    (cnt_last)
  );

  assign mem_valid = port_rd | port_wr;
  assign mem_we    = port_wr;
  assign mem_addr  = port_wr ? dst_q : src_q;
  assign mem_wdata = word_q;

  // R2: the port is used only under grant
  p_port_under_grant_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_valid |-> bus_gnt);

  // R5: a stalled beat holds steady
  p_stall_stable_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_addr)));
endmodule

// File: tb/dma_tenure_ctrl_tb_top.sv
module dma_tenure_ctrl_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_start;
  logic [1:0]    cfg_mode;
  logic [AW-1:0] cfg_src_addr, cfg_dst_addr;
  logic [CW-1:0] cfg_words;
  logic          periph_req, bus_req, bus_gnt;
  logic          mem_valid, mem_we, mem_ready, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  dma_tenure_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_words(cfg_words),
    .periph_req(periph_req), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done)
  );

  always #2.5 clk = ~clk;

  logic [DW-1:0] mem [256];
  exp_t          sb_q[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  int tenures, writes, ten_writes, owned_idle;
  int v_grant, v_stall, v_single, v_dem, v_gap;
  int preq_sel, wait_on, cpu_block, cur_mode, low_run;
  logic prev_valid, prev_we, prev_ready, prev_req, prev_preq;
  logic [AW-1:0] prev_addr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // arbiter, peripheral, memory model and scoreboard monitor
  always @(negedge clk) begin
    logic rdy, gnt_n;
    exp_t e;
    cyc++;
    if (rst_n) begin
      gnt_n = bus_req && (bus_gnt || !cpu_block);
      rdy   = (wait_on == 0) || ((cyc % 3) != 0);
      if (prev_valid && !prev_ready &&
          !(mem_valid && mem_we == prev_we && mem_addr == prev_addr)) v_stall++;
      if (mem_valid && !bus_gnt) v_grant++;
      if (cur_mode == 2 && mem_valid && !mem_we && !(prev_valid && !prev_we) && !prev_preq) v_dem++;
      if (low_run >= 6 && bus_req) v_gap++;
      if (bus_req && bus_gnt && !mem_valid) owned_idle++;
      if (bus_req && !prev_req) begin tenures++; ten_writes = 0; end
      if (!bus_req && prev_req && cur_mode == 0 && ten_writes != 1) v_single++;
      mem_rdata = mem[mem_addr[7:0]];
      if (mem_valid && rdy && mem_we) begin
        writes++; ten_writes++;
        mem[mem_addr[7:0]] = mem_wdata;
        if (sb_q.size() == 0) chk(1'b0, "R3 unexpected write", int'(mem_addr), -1);
        else begin
          e = sb_q.pop_front();
          chk(mem_addr == e.a, "R4 write address", int'(mem_addr), int'(e.a));
          chk(mem_wdata == e.d, "R3 write data", int'(mem_wdata), int'(e.d));
        end
      end
      prev_preq = periph_req;
      case (preq_sel)
        0:       periph_req = 1'b0;
        1:       periph_req = 1'b1;
        default: periph_req = (cyc % 20) < 12;
      endcase
      low_run = periph_req ? 0 : low_run + 1;
      prev_valid = mem_valid; prev_we = mem_we; prev_addr = mem_addr;
      prev_ready = rdy; prev_req = bus_req;
      mem_ready = rdy; bus_gnt = gnt_n;
    end
  end

  task automatic clear_stats();
    tenures = 0; writes = 0; owned_idle = 0;
    v_grant = 0; v_stall = 0; v_single = 0; v_dem = 0; v_gap = 0;
  endtask

  task automatic run_job(input int mode, input int src, input int dst, input int cnt,
                         input int psel, input int waits, input int hold);
    clear_stats();
    cur_mode = mode; preq_sel = psel; wait_on = waits; cpu_block = (hold > 0);
    for (int i = 0; i < cnt; i++)
      sb_q.push_back({AW'(dst + i), mem[(src + i) % 256]});
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_src_addr = AW'(src); cfg_dst_addr = AW'(dst);
    cfg_words = CW'(cnt); cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    chk(done == 1'b0, "R1 done cleared by start", int'(done), 0);
    if (hold > 0) begin
      for (int i = 0; i < hold; i++) @(negedge clk);
      chk(writes == 0 && bus_req, "R2 no beats while grant withheld", writes, 0);
      cpu_block = 0;
    end
    for (int k = 0; k < 4000 && !done; k++) @(negedge clk);
    chk(done == 1'b1, "R10 done after last word", int'(done), 1);
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk(sb_q.size() == 0, "R3 all words moved", sb_q.size(), 0);
    chk(writes == cnt, "R4 word count", writes, cnt);
    chk(v_grant == 0, "R2 beat without grant", v_grant, 0);
    chk(v_stall == 0, "R5 beat unstable during wait", v_stall, 0);
    chk(bus_req == 1'b0, "R10 bus released at end", int'(bus_req), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 + i * 32'h0001_0203;
    rst_n = 1'b0; cfg_start = 1'b0; cfg_mode = '0; cfg_src_addr = '0;
    cfg_dst_addr = '0; cfg_words = '0; periph_req = 1'b0; bus_gnt = 1'b0;
    mem_ready = 1'b0; mem_rdata = '0; preq_sel = 0; wait_on = 0; cpu_block = 0;
    cur_mode = 0; low_run = 0; prev_valid = 0; prev_we = 0; prev_ready = 0;
    prev_req = 0; prev_preq = 0; prev_addr = '0;
    clear_stats();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_req && !mem_valid && !done, "R10 reset state quiet", int'(bus_req), 0);

    // R11: zero count
    clear_stats();
    cfg_mode = 2'd1; cfg_words = '0; cfg_start = 1'b1;
    @(negedge clk); cfg_start = 1'b0;
    chk(done == 1'b1, "R11 zero count sets done", int'(done), 1);
    repeat (10) @(negedge clk);
    chk(tenures == 0, "R11 zero count never requests", tenures, 0);

    // R6: single mode, one word per tenure
    run_job(0, 4, 100, 4, 0, 0, 0);
    chk(tenures == 4, "R6 single tenures", tenures, 4);
    chk(v_single == 0, "R6 one word per tenure", v_single, 0);

    // R7: block mode with wait states
    run_job(1, 20, 120, 6, 0, 1, 0);
    chk(tenures == 1, "R7 block single tenure", tenures, 1);
    chk(owned_idle == 0, "R7 no idle owned cycles", owned_idle, 0);

    // R10: done sticky, no activity without a new start
    repeat (20) @(negedge clk);
    chk(done == 1'b1 && tenures == 1, "R10 done sticky and quiet", tenures, 1);

    // R12: mode 3 acts as block
    run_job(3, 30, 140, 3, 0, 0, 0);
    chk(tenures == 1, "R12 mode 3 single tenure", tenures, 1);

    // R2: processor holds the bus for a while
    run_job(1, 40, 150, 2, 0, 0, 12);
    chk(tenures == 1, "R2 tenure after delayed grant", tenures, 1);

    // R8: demand with steady request
    run_job(2, 50, 160, 5, 1, 0, 0);
    chk(tenures == 1, "R8 steady demand one tenure", tenures, 1);
    chk(owned_idle > 0, "R8 owned idle cycles occur", owned_idle, 1);
    chk(v_dem == 0, "R8 read started without request", v_dem, 0);

    // R9: demand with request gaps and wait states
    run_job(2, 60, 180, 12, 2, 1, 0);
    chk(tenures > 1, "R9 bus released on request gaps", tenures, 2);
    chk(v_gap == 0, "R9 bus held during long gap", v_gap, 0);
    chk(v_dem == 0, "R8 read started without request", v_dem, 0);
    preq_sel = 0;

    // R1: restart after done
    run_job(0, 80, 200, 1, 0, 1, 0);
    chk(tenures == 1, "R1 restart requests bus", tenures, 1);

    finish_run();
  end

  initial begin
    while (cyc < 100000) @(negedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
    finish_run();
  end
endmodule